// File: doc/BRIEF.md
# Width-Converting Request/Acknowledge Memory Port Adapter

This block connects a processing core's generic memory port to a physical single-port RAM whose word width may not match the core's logical word. The core raises a read or a write request together with an address and, for writes, data. It keeps all of them steady until the adapter answers with a one-cycle acknowledge. This transaction-style handshake means the same core works unchanged behind a dedicated memory or behind a shared memory that an arbiter grants only now and then.

On the memory side the adapter holds a request and waits for a grant before every physical access. The RAM returns read data one cycle after the granted access. Parameters select the width relation, and the adapter handles each case with its own conversion. With equal widths, or a wider RAM without packing, one logical word maps to one physical word and is zero-extended. With a wider RAM in packing mode, several logical words share one physical word as lanes, and a write becomes a read-modify-write. With a narrower RAM, each logical word is spread over consecutive physical words, one access per slice.

Top module: `mem_portal_adapter`

## Requirements
- R1: While reset is asserted and at the first sample after it is released, `core_ack`, `core_err` and `mem_req` are low and `core_rdata` is zero.
- R2: `core_ack` is high for exactly one cycle per request. The adapter does not start a second transaction from a request that is still held in its acknowledge cycle.
- R3: While `mem_req` is high and `mem_gnt` is low, `mem_addr`, `mem_we` and `mem_wdata` are held. A physical access takes place only in a cycle where both are high, so any grant delay leaves the stored and returned data unchanged.
- R4: Direct mapping (equal width, or a wider RAM with packing off) makes exactly one access at `mem_addr` = logical address. Writes store the word in bits [LOG_W-1:0] with every higher bit zero, and reads return bits [LOG_W-1:0].
- R5: Packing mode with ratio R = PHY_W/LOG_W uses physical address = logical address >> log2(R) and lane = the low log2(R) address bits. Lane k occupies bits [k*LOG_W +: LOG_W], so lane 0 is least significant. A write reads that physical word and then writes it back (two accesses), with only the addressed lane replaced.
- R6: In packing mode a read makes one access and returns the addressed lane.
- R7: Split mode with ratio R = LOG_W/PHY_W makes R accesses per request at physical addresses a*R + b, for b = 0 .. R-1 in ascending order. Beat b carries logical bits [b*PHY_W +: PHY_W]. The acknowledge follows the last beat.
- R8: `core_rdata` is valid in the acknowledge cycle of a read and does not change while no request is raised.
- R9: A request with both `core_rd` and `core_wr` high is served as a write, and `core_err` is high in its acknowledge cycle. For a legal request `core_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_addr | input | ADDR_W | Logical word address, held until acknowledge |
| core_wdata | input | LOG_W | Logical write data, held until acknowledge |
| core_rd | input | 1 | Read request |
| core_wr | input | 1 | Write request |
| core_rdata | output | LOG_W | Logical read data |
| core_ack | output | 1 | One-cycle completion pulse |
| core_err | output | 1 | Set with acknowledge when read and write were both requested |
| mem_req | output | 1 | Physical access request |
| mem_gnt | input | 1 | Grant; the access happens in a cycle with request and grant |
| mem_we | output | 1 | Physical write enable |
| mem_addr | output | PADDR_W | Physical word address |
| mem_wdata | output | PHY_W | Physical write data |
| mem_rdata | input | PHY_W | Physical read data, one cycle after the granted access |

## Verification
The bench runs four adapters side by side: equal widths, a zero-padded wider RAM, a packed wider RAM and a split narrower RAM. Each is checked against a logical shadow memory, from which the expected physical words are derived. Writes to neighbouring lanes catch a packing adapter that merges into a stale or wrong lane, or that overwrites the whole word. Checks on the beat count and on the first physical address catch a split adapter that reverses slice order or acknowledges early. Random grant stalls expose an adapter that moves its address or data before the grant, or that samples read data a cycle off. Doubled read/write requests and idle gaps after reads catch a missing error flag, a read served in place of the write, and output data that drifts between transactions.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

   typedef enum logic [1:0] {
      MAP_DIRECT = 2'd0,
      MAP_PACK   = 2'd1,
      MAP_SPLIT  = 2'd2
   } map_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACC  = 2'd1,
      ST_RDW  = 2'd2
   } st_e;

   function automatic map_e pick_map(input int lw, input int pw, input int pk);
      if (pw > lw && pk != 0) return MAP_PACK;
      if (pw < lw)            return MAP_SPLIT;
      return MAP_DIRECT;
   endfunction

   function automatic int ratio(input int lw, input int pw);
      return (pw > lw) ? pw / lw : lw / pw;
   endfunction

   function automatic int sel_w(input int r);
      return (r <= 1) ? 1 : $clog2(r);
   endfunction

   function automatic int paddr_w(input int aw, input int lw, input int pw, input int pk);
      map_e m;
      m = pick_map(lw, pw, pk);
      if (m == MAP_PACK)  return aw - $clog2(ratio(lw, pw));
      if (m == MAP_SPLIT) return aw + $clog2(ratio(lw, pw));
      return aw;
   endfunction

endpackage

// File: rtl/mpa_addr_map.sv
module mpa_addr_map
   import mpa_pkg::*;
#(
   parameter map_e MAP     = MAP_DIRECT,
   parameter int   ADDR_W  = 8,
   parameter int   PADDR_W = 8,
   parameter int   SEL_W   = 1
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [SEL_W-1:0]   beat,
   output logic [PADDR_W-1:0] paddr,
   output logic [SEL_W-1:0]   lane
);

   generate
      if (MAP == MAP_PACK) begin : g_pack
         assign paddr = addr[ADDR_W-1:ADDR_W-PADDR_W];
         assign lane  = addr[SEL_W-1:0];
         logic unused_beat;
         assign unused_beat = ^beat;
      end else if (MAP == MAP_SPLIT) begin : g_split
         assign paddr = {addr, beat};
         assign lane  = '0;
      end else begin : g_direct
         assign paddr = addr;
         assign lane  = '0;
         logic unused_beat;
         assign unused_beat = ^beat;
      end
   endgenerate

endmodule

// File: rtl/mpa_lane.sv
module mpa_lane
   import mpa_pkg::*;
#(
   parameter map_e MAP   = MAP_DIRECT,
   parameter int   LOG_W = 16,
   parameter int   PHY_W = 32,
   parameter int   SEL_W = 1
) (
   input  logic [LOG_W-1:0] wdata,
   input  logic [SEL_W-1:0] lane,
   input  logic [SEL_W-1:0] beat,
   input  logic [PHY_W-1:0] old_word,
   input  logic [PHY_W-1:0] rword,
   input  logic [LOG_W-1:0] cur,
   output logic [PHY_W-1:0] phy_wdata,
   output logic [LOG_W-1:0] rd_next
);

   generate
      if (MAP == MAP_PACK) begin : g_pack
         always_comb begin
            phy_wdata = old_word;
            phy_wdata[int'(lane)*LOG_W +: LOG_W] = wdata;
            rd_next = rword[int'(lane)*LOG_W +: LOG_W];
         end
         logic unused_in;
         assign unused_in = ^{beat, cur};
      end else if (MAP == MAP_SPLIT) begin : g_split
         always_comb begin
            phy_wdata = wdata[int'(beat)*PHY_W +: PHY_W];
            rd_next = cur;
            rd_next[int'(beat)*PHY_W +: PHY_W] = rword;
         end
         logic unused_in;
         assign unused_in = ^{lane, old_word};
      end else begin : g_direct
         assign phy_wdata = PHY_W'(wdata);
         assign rd_next   = rword[LOG_W-1:0];
         logic unused_in;
         assign unused_in = ^{lane, beat, old_word, cur, rword};
      end
   endgenerate

endmodule

// File: rtl/mpa_ctrl.sv
module mpa_ctrl
   import mpa_pkg::*;
#(
   parameter map_e MAP   = MAP_DIRECT,
   parameter int   SEL_W = 1,
   parameter int   LAST  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             core_rd,
   input  logic             core_wr,
   input  logic             mem_gnt,
   output logic             mem_req,
   output logic             mem_we,
   output logic             cap_en,
   output logic             word_ld,
   output logic             rd_ld,
   output logic [SEL_W-1:0] beat,
   output logic             ack,
   output logic             err
);

   st_e  state;
   logic op_wr, err_p, wb, last_beat;

   always_comb begin
      cap_en    = (state == ST_IDLE) && !ack && (core_rd || core_wr);
      word_ld   = (state == ST_RDW) && op_wr;
      rd_ld     = (state == ST_RDW) && !op_wr;
      last_beat = (MAP != MAP_SPLIT) || (beat == SEL_W'(LAST));
      mem_req   = (state == ST_ACC);
      mem_we    = (state == ST_ACC) && op_wr && ((MAP != MAP_PACK) || wb);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         op_wr <= 1'b0;
         err_p <= 1'b0;
         wb    <= 1'b0;
         beat  <= '0;
         ack   <= 1'b0;
         err   <= 1'b0;
      end else begin
         ack <= 1'b0;
         err <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (cap_en) begin
                  state <= ST_ACC;
                  op_wr <= core_wr;
                  err_p <= core_rd && core_wr;
                  wb    <= 1'b0;
                  beat  <= '0;
               end
            end
            ST_ACC: begin
               if (mem_gnt) begin
                  if (!op_wr || (MAP == MAP_PACK && !wb)) begin
                     state <= ST_RDW;
                  end else if (!last_beat) begin
                     beat <= beat + 1'b1;
                  end else begin
                     state <= ST_IDLE;
                     ack   <= 1'b1;
                     err   <= err_p;
                  end
               end
            end
            ST_RDW: begin
               if (op_wr) begin
                  wb    <= 1'b1;
                  state <= ST_ACC;
               end else if (!last_beat) begin
                  beat  <= beat + 1'b1;
                  state <= ST_ACC;
               end else begin
                  state <= ST_IDLE;
                  ack   <= 1'b1;
                  err   <= err_p;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mem_portal_adapter.sv
module mem_portal_adapter
   import mpa_pkg::*;
#(
   parameter  int LOG_W   = 16,
   parameter  int PHY_W   = 32,
   parameter  int ADDR_W  = 10,
   parameter  int PACK    = 1,
   localparam int PADDR_W = mpa_pkg::paddr_w(ADDR_W, LOG_W, PHY_W, PACK)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  core_addr,
   input  logic [LOG_W-1:0]   core_wdata,
   input  logic               core_rd,
   input  logic               core_wr,
   output logic [LOG_W-1:0]   core_rdata,
   output logic               core_ack,
   output logic               core_err,
   output logic               mem_req,
   input  logic               mem_gnt,
   output logic               mem_we,
   output logic [PADDR_W-1:0] mem_addr,
   output logic [PHY_W-1:0]   mem_wdata,
   input  logic [PHY_W-1:0]   mem_rdata
);

   localparam map_e MAP   = pick_map(LOG_W, PHY_W, PACK);
   localparam int   RATIO = ratio(LOG_W, PHY_W);
   localparam int   SEL_W = sel_w(RATIO);
   localparam int   LAST  = (MAP == MAP_SPLIT) ? RATIO - 1 : 0;

   // elaboration-time parameter checks
   generate
      if (LOG_W < 1 || PHY_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("widths must be positive");
      end
      if (MAP != MAP_DIRECT) begin : g_ratio_chk
         if ((PHY_W > LOG_W ? PHY_W % LOG_W : LOG_W % PHY_W) != 0) begin : g_bad_div
            $error("wide width must be a multiple of narrow width");
         end
         if ((RATIO & (RATIO - 1)) != 0) begin : g_bad_pow2
            $error("width ratio must be a power of two");
         end
      end
      if (MAP == MAP_PACK && ADDR_W <= $clog2(RATIO)) begin : g_bad_addr
         $error("address too narrow for packing ratio");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic [LOG_W-1:0]  wdata_q, rd_next;
   logic [PHY_W-1:0]  old_word;
   logic [SEL_W-1:0]  beat, lane;
   logic              cap_en, word_ld, rd_ld;

   mpa_ctrl #(.MAP(MAP), .SEL_W(SEL_W), .LAST(LAST)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .core_rd (core_rd),
      .core_wr (core_wr),
      .mem_gnt (mem_gnt),
      .mem_req (mem_req),
      .mem_we  (mem_we),
      .cap_en  (cap_en),
      .word_ld (word_ld),
      .rd_ld   (rd_ld),
      .beat    (beat),
      .ack     (core_ack),
      .err     (core_err)
   );

   mpa_addr_map #(.MAP(MAP), .ADDR_W(ADDR_W), .PADDR_W(PADDR_W), .SEL_W(SEL_W)) u_map (
      .addr  (addr_q),
      .beat  (beat),
      .paddr (mem_addr),
      .lane  (lane)
   );

   mpa_lane #(.MAP(MAP), .LOG_W(LOG_W), .PHY_W(PHY_W), .SEL_W(SEL_W)) u_lane (
      .wdata     (wdata_q),
      .lane      (lane),
      .beat      (beat),
      .old_word  (old_word),
      .rword     (mem_rdata),
      .cur       (core_rdata),
      .phy_wdata (mem_wdata),
      .rd_next   (rd_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q     <= '0;
         wdata_q    <= '0;
         old_word   <= '0;
         core_rdata <= '0;
      end else begin
         if (cap_en) begin
            addr_q  <= core_addr;
            wdata_q <= core_wdata;
         end
         if (word_ld) old_word   <= mem_rdata;
         if (rd_ld)   core_rdata <= rd_next;
      end
   end

endmodule

// File: rtl/mem_portal_adapter_chk.sv
module mem_portal_adapter_chk #(
   parameter int LOG_W   = 16,
   parameter int PHY_W   = 32,
   parameter int PADDR_W = 9
) (
   input logic               clk,
   input logic               rst_n,
   input logic               core_rd,
   input logic               core_wr,
   input logic               core_ack,
   input logic               core_err,
   input logic [LOG_W-1:0]   core_rdata,
   input logic               mem_req,
   input logic               mem_gnt,
   input logic               mem_we,
   input logic [PADDR_W-1:0] mem_addr,
   input logic [PHY_W-1:0]   mem_wdata
);

   // R2: acknowledge lasts one cycle
   a_r2_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      core_ack |=> !core_ack);

   // R2: acknowledge only answers a raised request
   a_r2_ack_has_req: assert property (@(posedge clk) disable iff (!rst_n)
      core_ack |-> $past(core_rd || core_wr));

   // R3: memory request and its fields wait for grant unchanged
   a_r3_hold_until_gnt: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));

   // R8: read data steady while the core is idle
   a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_rd && !core_wr && !mem_req) |=> $stable(core_rdata));

   // R9: error flag only accompanies an acknowledge
   a_r9_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      core_err |-> core_ack);

endmodule

bind mem_portal_adapter mem_portal_adapter_chk #(
   .LOG_W(LOG_W), .PHY_W(PHY_W), .PADDR_W(PADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .core_rd    (core_rd),
   .core_wr    (core_wr),
   .core_ack   (core_ack),
   .core_err   (core_err),
   .core_rdata (core_rdata),
   .mem_req    (mem_req),
   .mem_gnt    (mem_gnt),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata)
);

// File: tb/mpa_harness.sv
module mpa_harness #(
   parameter int LOG_W  = 16,
   parameter int PHY_W  = 16,
   parameter int PACK   = 0,
   parameter int ADDR_W = 6,
   parameter int SEED   = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic done,
   output int   checks,
   output int   fails
);

   localparam bit IS_PACK  = (PHY_W > LOG_W) && (PACK != 0);
   localparam bit IS_SPLIT = (PHY_W < LOG_W);
   localparam int R        = IS_PACK ? PHY_W / LOG_W : (IS_SPLIT ? LOG_W / PHY_W : 1);
   localparam int SH       = (R > 1) ? $clog2(R) : 0;
   localparam int PAW      = IS_PACK ? ADDR_W - SH : (IS_SPLIT ? ADDR_W + SH : ADDR_W);
   localparam int WMAX     = (PHY_W > LOG_W) ? PHY_W : LOG_W;

   logic [ADDR_W-1:0] core_addr;
   logic [LOG_W-1:0]  core_wdata, core_rdata;
   logic              core_rd, core_wr, core_ack, core_err;
   logic              mem_req, mem_gnt, mem_we;
   logic [PAW-1:0]    mem_addr;
   logic [PHY_W-1:0]  mem_wdata, ram_q;

   logic [LOG_W-1:0]  refm [2**ADDR_W];
   logic [PHY_W-1:0]  ram  [2**PAW];

   int             n_acc;
   logic [PAW-1:0] first_addr;
   int             gnt_pct;

   mem_portal_adapter #(.LOG_W(LOG_W), .PHY_W(PHY_W), .ADDR_W(ADDR_W), .PACK(PACK)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .core_addr  (core_addr),
      .core_wdata (core_wdata),
      .core_rd    (core_rd),
      .core_wr    (core_wr),
      .core_rdata (core_rdata),
      .core_ack   (core_ack),
      .core_err   (core_err),
      .mem_req    (mem_req),
      .mem_gnt    (mem_gnt),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (ram_q)
   );

   // RAM model: access on request and grant, read data one cycle later
   always @(posedge clk) begin
      if (mem_req && mem_gnt) begin
         if (mem_we) ram[mem_addr] <= mem_wdata;
         ram_q <= ram[mem_addr];
         if (n_acc == 0) first_addr = mem_addr;
         n_acc = n_acc + 1;
      end
   end

   always @(negedge clk) mem_gnt <= (($urandom % 100) < gnt_pct);

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s in %m: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [PHY_W-1:0] exp_phys(input int p);
      logic [WMAX-1:0] t;
      t = '0;
      if (IS_PACK) begin
         for (int k = 0; k < R; k++) t = t | (WMAX'(refm[p*R + k]) << (k*LOG_W));
      end else if (IS_SPLIT) begin
         t = WMAX'(refm[p >> SH]) >> ((p % R) * PHY_W);
      end else begin
         t = WMAX'(refm[p]);
      end
      return t[PHY_W-1:0];
   endfunction

   function automatic string wtag();
      return IS_PACK ? "R5" : (IS_SPLIT ? "R7" : "R4");
   endfunction

   function automatic string rtag();
      return IS_PACK ? "R6" : (IS_SPLIT ? "R7" : "R4");
   endfunction

   task automatic do_op(input bit rd, input bit wr, input logic [ADDR_W-1:0] a,
                        input logic [LOG_W-1:0] d, output logic [LOG_W-1:0] q,
                        output bit e, output int acc);
      int t;
      @(negedge clk);
      core_rd = rd; core_wr = wr; core_addr = a; core_wdata = d;
      n_acc = 0;
      t = 0;
      do begin
         @(negedge clk);
         t++;
      end while (!core_ack && t < 2000);
      chk(core_ack, "R2 acknowledge arrives", core_ack, 1);
      q = core_rdata; e = core_err; acc = n_acc;
      core_rd = 0; core_wr = 0;
      @(negedge clk);
      chk(!core_ack, "R2 acknowledge single cycle", core_ack, 0);
      chk(n_acc == acc, "R2 no restart in acknowledge cycle", n_acc, acc);
   endtask

   task automatic wr_op(input logic [ADDR_W-1:0] a, input logic [LOG_W-1:0] d,
                        input bit both, input string tg);
      logic [LOG_W-1:0] q;
      bit e;
      int acc, p0, exp_acc, exp_first;
      do_op(both, 1'b1, a, d, q, e, acc);
      refm[a] = d;
      exp_acc   = IS_PACK ? 2 : R;
      p0        = IS_PACK ? (int'(a) >> SH) : (IS_SPLIT ? (int'(a) << SH) : int'(a));
      exp_first = p0;
      chk(acc == exp_acc, {tg, " write access count"}, acc, exp_acc);
      chk(int'(first_addr) == exp_first, {tg, " write first address"}, first_addr, exp_first);
      chk(e == both, both ? "R9 error flag on double request" : "R9 no error on legal write",
          e, both);
      for (int b = 0; b < (IS_SPLIT ? R : 1); b++)
         chk(ram[p0 + b] == exp_phys(p0 + b), {tg, " stored physical word"},
             ram[p0 + b], exp_phys(p0 + b));
   endtask

   task automatic rd_op(input logic [ADDR_W-1:0] a, input string tg);
      logic [LOG_W-1:0] q;
      bit e;
      int acc, exp_acc, exp_first;
      do_op(1'b1, 1'b0, a, '0, q, e, acc);
      exp_acc   = IS_SPLIT ? R : 1;
      exp_first = IS_PACK ? (int'(a) >> SH) : (IS_SPLIT ? (int'(a) << SH) : int'(a));
      chk(q == refm[a], {tg, " read data"}, q, refm[a]);
      chk(acc == exp_acc, {tg, " read access count"}, acc, exp_acc);
      chk(int'(first_addr) == exp_first, {tg, " read first address"}, first_addr, exp_first);
      chk(!e, "R9 no error on legal read", e, 0);
   endtask

   initial begin
      logic [LOG_W-1:0] held;
      done = 0; checks = 0; fails = 0;
      core_rd = 0; core_wr = 0; core_addr = '0; core_wdata = '0;
      n_acc = 0; gnt_pct = 100; ram_q = '0; first_addr = '0;
      void'($urandom(SEED));
      for (int i = 0; i < 2**ADDR_W; i++) refm[i] = '0;
      for (int i = 0; i < 2**PAW; i++) ram[i] = '0;
      wait (rst_n === 1'b1);
      @(negedge clk);
      // R1 reset state
      chk(!core_ack && !core_err, "R1 ack/err low after reset", {core_ack, core_err}, 0);
      chk(!mem_req, "R1 no memory request after reset", mem_req, 0);
      chk(core_rdata == '0, "R1 read data zero after reset", core_rdata, 0);

      // directed: neighbouring lanes / slices, all-ones pattern
      wr_op(6'd4, '1, 1'b0, wtag());
      wr_op(6'd5, LOG_W'(32'h0000_5A5A), 1'b0, wtag());
      wr_op(6'd6, LOG_W'(32'h1234_8001), 1'b0, wtag());
      rd_op(6'd4, rtag());
      rd_op(6'd5, rtag());
      rd_op(6'd7, rtag());
      // R8: read data held while idle
      rd_op(6'd6, rtag());
      held = core_rdata;
      repeat (5) @(negedge clk);
      chk(core_rdata == held, "R8 read data held while idle", core_rdata, held);
      // R9: read and write together are served as a write
      wr_op(6'd9, LOG_W'(32'hC3C3_3C3C), 1'b1, "R9");
      rd_op(6'd9, "R9");

      // random traffic, full grant then stalled grant
      for (int ph = 0; ph < 2; ph++) begin
         gnt_pct = (ph == 0) ? 100 : 30;
         for (int n = 0; n < 40; n++) begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'($urandom);
            if ($urandom % 2) wr_op(a, LOG_W'($urandom), 1'b0, ph ? "R3" : wtag());
            else              rd_op(a, ph ? "R3" : rtag());
         end
      end
      gnt_pct = 100;
      done = 1;
   end

endmodule

// File: tb/mem_portal_adapter_tb.sv
module mem_portal_adapter_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WD_LIMIT   = 150000;

   logic clk, rst_n;
   logic d_eq, d_pad, d_pack, d_split;
   int   c_eq, c_pad, c_pack, c_split;
   int   f_eq, f_pad, f_pack, f_split;

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   mpa_harness #(.LOG_W(16), .PHY_W(16), .PACK(0), .SEED(11)) u_eq (
      .clk(clk), .rst_n(rst_n), .done(d_eq), .checks(c_eq), .fails(f_eq));
   mpa_harness #(.LOG_W(12), .PHY_W(32), .PACK(0), .SEED(22)) u_pad (
      .clk(clk), .rst_n(rst_n), .done(d_pad), .checks(c_pad), .fails(f_pad));
   mpa_harness #(.LOG_W(8), .PHY_W(32), .PACK(1), .SEED(33)) u_pack (
      .clk(clk), .rst_n(rst_n), .done(d_pack), .checks(c_pack), .fails(f_pack));
   mpa_harness #(.LOG_W(32), .PHY_W(8), .PACK(0), .SEED(44)) u_split (
      .clk(clk), .rst_n(rst_n), .done(d_split), .checks(c_split), .fails(f_split));

   initial begin
      rst_n = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   end

   initial begin
      int cyc, checks, failures;
      cyc = 0;
      while (!(d_eq === 1'b1 && d_pad === 1'b1 && d_pack === 1'b1 && d_split === 1'b1)
             && cyc < WD_LIMIT) begin
         @(posedge clk);
         cyc++;
      end
      @(negedge clk);
      checks   = c_eq + c_pad + c_pack + c_split;
      failures = f_eq + f_pad + f_pack + f_split;
      if (cyc >= WD_LIMIT) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=%0d cycles expected=below %0d", cyc, WD_LIMIT);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule